// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a two-wire synchronous link in which it is always the clock master. One output carries a shift clock that the block generates from the system clock. A single data line, shown here as a separate input, output and output enable so that the pad sits outside the block, carries the bits in one direction at a time. The link is half duplex. The core starts a transmission by writing a byte. It starts a reception by raising an enable level while the receive-done flag is clear.

Each bit occupies a fixed slot of twelve system clocks. The shift clock idles high. In each slot it drops for six clocks and returns high ten clocks after the slot begins. On transmit, the outgoing bit changes at the start of the slot. That gives ten clocks of setup before the rising shift-clock edge and two clocks of hold after it. On receive, the line is captured on the rising edge itself. Bits travel least significant first. After the eighth bit a sticky done flag is raised, and only the core clears it.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, sclk is 1, sd_oe is 0, tx_done and rx_done are 0, and rx_byte is 0x00.
- R2: A tx_wr pulse while no transfer runs starts a transmission on the next clock edge. sd_oe is then 1 for exactly 96 consecutive clocks (8 slots of 12).
- R3: While a transfer runs, sclk goes low for exactly 6 clocks per slot and its rising edges are exactly 12 clocks apart. There are 8 rising edges per transfer, and sclk stays 1 whenever no transfer runs.
- R4: On transmit, the byte appears on sd_out least significant bit first. Each bit is stable for at least 10 clocks before the rising sclk edge at which it is read, and it stays valid one more clock after that edge.
- R5: A reception starts when rx_en is 1, rx_done is 0 and no transfer runs. During a reception sd_oe stays 0 and sclk still produces 8 rising edges.
- R6: On receive, bit k of rx_byte (bit 0 first) is the value sd_in held in the clock before the k-th rising sclk edge. rx_byte is updated when rx_done rises.
- R7: tx_done or rx_done is set at the end of the eighth slot of the matching transfer; tx_done rises in the same cycle that sd_oe falls. A flag stays 1 until its clear input is pulsed.
- R8: tx_wr during a running transfer is ignored: the current byte and its timing are not disturbed, and no second transfer follows.
- R9: While rx_done is 1, rx_en has no effect and sclk stays 1. Clearing rx_done with rx_en still 1 starts a new reception.
- R10: When tx_wr and a valid receive start occur in the same cycle, the transmission wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all shift timing counts its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | One-cycle strobe that loads tx_byte and starts a transmission |
| tx_byte | input | DATA_W | Byte to transmit |
| rx_en | input | 1 | Receive enable level |
| tx_done_clr | input | 1 | Clears tx_done |
| rx_done_clr | input | 1 | Clears rx_done |
| sd_in | input | 1 | Data line as seen from the pad |
| sclk | output | 1 | Shift clock, idle high |
| sd_out | output | 1 | Data driven toward the pad |
| sd_oe | output | 1 | Pad output enable, high only while transmitting |
| tx_done | output | 1 | Sticky transmit-complete flag |
| rx_done | output | 1 | Sticky receive-complete flag |
| rx_byte | output | DATA_W | Last byte received |

## Verification
The hardest property to show from the pins is that reception captures the line on the rising edge and at no other point of the slot. A bench that holds each bit steady for the whole slot would pass a design that sampled anywhere in the slot. The slave model in the bench therefore drives the inverse of each bit for most of the low phase. It presents the true bit only in the single clock before the rising edge and flips it again once the edge is seen. A second hard case is a write strobe or an enable that arrives while the block is busy or the flag is still set. The bench reaches it by pulsing tx_wr in the middle of a transfer and by leaving rx_en high across a completed reception. It then confirms that the output-enable count, the byte and the shift clock are undisturbed.

// File: rtl/sps_pkg.sv
package sps_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_TX   = 2'd1,
      MODE_RX   = 2'd2
   } sps_mode_e;

   localparam int FLAG_TX = 0;
   localparam int FLAG_RX = 1;
   localparam int N_FLAGS = 2;
endpackage

// File: rtl/sps_timing.sv
module sps_timing #(
   parameter int BIT_CLKS   = 12,
   parameter int SETUP_CLKS = 10,
   parameter int LOW_CLKS   = 6,
   parameter int NBITS      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic sample_pt,
   output logic shift_pt,
   output logic xfer_end,
   output logic sclk
);
   localparam int PW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
   localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
   localparam logic [PW-1:0] PH_LAST = PW'(BIT_CLKS - 1);
   localparam logic [PW-1:0] PH_FALL = PW'(SETUP_CLKS - LOW_CLKS);
   localparam logic [PW-1:0] PH_RISE = PW'(SETUP_CLKS);
   localparam logic [PW-1:0] PH_SAMP = PW'(SETUP_CLKS - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

   logic [PW-1:0] phase_q, phase_d;
   logic [BW-1:0] bit_q, bit_d;
   logic          active_q, active_d;
   logic          sclk_q, sclk_d;

   // next-state of the slot counters
   always_comb begin
      phase_d  = phase_q;
      bit_d    = bit_q;
      active_d = active_q;
      if (start) begin
         active_d = 1'b1;
         phase_d  = '0;
         bit_d    = '0;
      end else if (active_q) begin
         if (phase_q == PH_LAST) begin
            phase_d = '0;
            if (bit_q == BIT_LAST) active_d = 1'b0;
            else                   bit_d    = bit_q + 1'b1;
         end else begin
            phase_d = phase_q + 1'b1;
         end
      end
   end

   // shift clock registered from next state so the pin never glitches
   always_comb begin
      sclk_d = !(active_d && (phase_d >= PH_FALL) && (phase_d < PH_RISE));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= '0;
         bit_q    <= '0;
         active_q <= 1'b0;
         sclk_q   <= 1'b1;
      end else begin
         phase_q  <= phase_d;
         bit_q    <= bit_d;
         active_q <= active_d;
         sclk_q   <= sclk_d;
      end
   end

   assign active    = active_q;
   assign sclk      = sclk_q;
   assign sample_pt = active_q && (phase_q == PH_SAMP);
   assign shift_pt  = active_q && (phase_q == PH_LAST) && (bit_q != BIT_LAST);
   assign xfer_end  = active_q && (phase_q == PH_LAST) && (bit_q == BIT_LAST);
endmodule

// File: rtl/sps_shifter.sv
module sps_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_tx,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              clear_rx,
   input  logic              shift_tx,
   input  logic              sample_rx,
   input  logic              finish_rx,
   input  logic              sd_in,
   output logic              sd_out,
   output logic [DATA_W-1:0] rx_byte
);
   logic [DATA_W-1:0] shreg_q;
   logic              out_q;
   logic [DATA_W-1:0] rx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
         out_q   <= 1'b0;
      end else if (load_tx) begin
         shreg_q <= tx_byte;
         out_q   <= tx_byte[0];
      end else if (clear_rx) begin
         shreg_q <= '0;
      end else if (shift_tx) begin
         shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
         out_q   <= shreg_q[1];
      end else if (sample_rx) begin
         shreg_q <= {sd_in, shreg_q[DATA_W-1:1]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         rx_q <= '0;
      else if (finish_rx) rx_q <= shreg_q;
   end

   assign sd_out  = out_q;
   assign rx_byte = rx_q;
endmodule

// File: rtl/sps_flags.sv
module sps_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      f_q <= 1'b0;
         else if (set[g]) f_q <= 1'b1;
         else if (clr[g]) f_q <= 1'b0;
      end
      assign flag[g] = f_q;
   end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
   import sps_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BIT_CLKS   = 12,
   parameter int SETUP_CLKS = 10,
   parameter int LOW_CLKS   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              rx_en,
   input  logic              tx_done_clr,
   input  logic              rx_done_clr,
   input  logic              sd_in,
   output logic              sclk,
   output logic              sd_out,
   output logic              sd_oe,
   output logic              tx_done,
   output logic              rx_done,
   output logic [DATA_W-1:0] rx_byte
);
   // parameter sanity at elaboration
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (SETUP_CLKS >= BIT_CLKS) begin : g_bad_setup
      $error("SETUP_CLKS must leave at least one hold clock");
   end
   if (LOW_CLKS < 1 || LOW_CLKS >= SETUP_CLKS) begin : g_bad_low
      $error("LOW_CLKS must be within 1 .. SETUP_CLKS-1");
   end

   sps_mode_e    mode_q;
   logic         timing_active;
   logic         sample_pt, shift_pt, xfer_end;
   logic         start_tx, start_rx;
   logic         oe_q;
   logic         mode_is_rx, mode_is_tx;
   logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

   assign start_tx   = tx_wr && !timing_active;
   assign start_rx   = rx_en && !rx_done && !timing_active && !tx_wr;
   assign mode_is_rx = (mode_q == MODE_RX);
   assign mode_is_tx = (mode_q == MODE_TX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_IDLE;
         oe_q   <= 1'b0;
      end else begin
         if (start_tx)      mode_q <= MODE_TX;
         else if (start_rx) mode_q <= MODE_RX;
         else if (xfer_end) mode_q <= MODE_IDLE;

         if (start_tx)      oe_q <= 1'b1;
         else if (xfer_end) oe_q <= 1'b0;
      end
   end

   sps_timing #(
      .BIT_CLKS  (BIT_CLKS),
      .SETUP_CLKS(SETUP_CLKS),
      .LOW_CLKS  (LOW_CLKS),
      .NBITS     (DATA_W)
   ) i_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_tx || start_rx),
      .active   (timing_active),
      .sample_pt(sample_pt),
      .shift_pt (shift_pt),
      .xfer_end (xfer_end),
      .sclk     (sclk)
   );

   sps_shifter #(
      .DATA_W(DATA_W)
   ) i_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_tx  (start_tx),
      .tx_byte  (tx_byte),
      .clear_rx (start_rx),
      .shift_tx (shift_pt && mode_is_tx),
      .sample_rx(sample_pt && mode_is_rx),
      .finish_rx(xfer_end && mode_is_rx),
      .sd_in    (sd_in),
      .sd_out   (sd_out),
      .rx_byte  (rx_byte)
   );

   always_comb begin
      flag_set          = '0;
      flag_clr          = '0;
      flag_set[FLAG_TX] = xfer_end && mode_is_tx;
      flag_set[FLAG_RX] = xfer_end && mode_is_rx;
      flag_clr[FLAG_TX] = tx_done_clr;
      flag_clr[FLAG_RX] = rx_done_clr;
   end

   sps_flags #(
      .N(N_FLAGS)
   ) i_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set),
      .clr  (flag_clr),
      .flag (flag_q)
   );

   assign sd_oe   = oe_q;
   assign tx_done = flag_q[FLAG_TX];
   assign rx_done = flag_q[FLAG_RX];
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
   parameter int LOW_CLKS = 6
) (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic sd_out,
   input logic sd_oe,
   input logic tx_done,
   input logic tx_done_clr,
   input logic rx_done,
   input logic rx_done_clr,
   input logic active,
   input logic is_rx
);
   localparam int CW = $clog2(LOW_CLKS + 2) + 1;
   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)    low_cnt <= '0;
      else if (sclk) low_cnt <= '0;
      else           low_cnt <= low_cnt + 1'b1;
   end

   assert_sclk_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> (low_cnt == CW'(LOW_CLKS)));

   assert_idle_sclk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> sclk);

   assert_data_stable_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk && $past(!sclk)) |-> $stable(sd_out));

   assert_rx_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && is_rx) |-> !sd_oe);

   assert_txdone_with_oe_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $fell(sd_oe));

   assert_txdone_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !tx_done_clr) |=> tx_done);

   assert_rxdone_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rx_done_clr) |=> rx_done);

   assert_rx_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rx_done_clr && !active) |=> (!active || sd_oe));
endmodule

bind sync_shift_port sps_checker #(
   .LOW_CLKS(LOW_CLKS)
) i_sps_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sclk       (sclk),
   .sd_out     (sd_out),
   .sd_oe      (sd_oe),
   .tx_done    (tx_done),
   .tx_done_clr(tx_done_clr),
   .rx_done    (rx_done),
   .rx_done_clr(rx_done_clr),
   .active     (timing_active),
   .is_rx      (mode_is_rx)
);

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       rx_en = 1'b0;
   logic       tx_done_clr = 1'b0;
   logic       rx_done_clr = 1'b0;
   logic       sd_in = 1'b1;
   logic       sclk, sd_out, sd_oe, tx_done, rx_done;
   logic [7:0] rx_byte;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] txq[$];
   logic [7:0] rxq[$];

   // slave model state
   logic [7:0] slave_byte = 8'h00;
   int         slave_idx  = 0;

   // monitor state
   logic       prev_sclk = 1'b1, prev_oe = 1'b0, prev_sd = 1'b0, prev_rxd = 1'b0;
   int         stable_cnt = 0, low_m = 0, samp_cyc = 0, last_rise = 0;
   int         xfer_rises = 0, tx_bits = 0, rx_rises = 0, oe_cnt = 0, total_falls = 0;
   logic [7:0] tx_acc = 8'h00;
   logic       hold_pending = 1'b0, hold_bit = 1'b0;

   always #4 clk = ~clk;

   sync_shift_port i_sync_shift_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_wr      (tx_wr),
      .tx_byte    (tx_byte),
      .rx_en      (rx_en),
      .tx_done_clr(tx_done_clr),
      .rx_done_clr(rx_done_clr),
      .sd_in      (sd_in),
      .sclk       (sclk),
      .sd_out     (sd_out),
      .sd_oe      (sd_oe),
      .tx_done    (tx_done),
      .rx_done    (rx_done),
      .rx_byte    (rx_byte)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor and scoreboard, plus the receive-side slave
   always @(negedge clk) begin
      if (rst_n) begin
         samp_cyc++;
         if (sd_out == prev_sd) stable_cnt++;
         else                   stable_cnt = 0;
         if (hold_pending) begin
            chk(sd_out == hold_bit, "R4 hold after rise", sd_out, hold_bit);
            hold_pending = 1'b0;
         end
         if (!sclk) low_m++;
         if (!sclk && prev_sclk) begin
            total_falls++;
            if (!sd_oe) sd_in = ~slave_byte[slave_idx[2:0]];
         end
         if (!sclk && !sd_oe && low_m == 6) sd_in = slave_byte[slave_idx[2:0]];
         if (sclk && !prev_sclk) begin
            chk(low_m == 6, "R3 low width", low_m, 6);
            if (xfer_rises > 0)
               chk(samp_cyc - last_rise == 12, "R3 rise spacing", samp_cyc - last_rise, 12);
            last_rise = samp_cyc;
            xfer_rises++;
            if (sd_oe) begin
               chk(stable_cnt >= 10, "R4 setup before rise", stable_cnt, 10);
               tx_acc       = {sd_out, tx_acc[7:1]};
               tx_bits++;
               hold_pending = 1'b1;
               hold_bit     = sd_out;
            end else begin
               rx_rises++;
               slave_idx++;
               sd_in = ~slave_byte[slave_idx[2:0]];
            end
         end
         if (sclk) low_m = 0;
         if (sd_oe) oe_cnt++;
         if (prev_oe && !sd_oe) begin
            chk(oe_cnt == 96, "R2 output enable length", oe_cnt, 96);
            chk(tx_done == 1'b1, "R7 tx_done with oe drop", tx_done, 1);
            chk(tx_bits == 8, "R3 tx rising edges", tx_bits, 8);
            if (txq.size() == 0) begin
               chk(1'b0, "R8 unexpected transmission", tx_acc, 0);
            end else begin
               logic [7:0] e;
               e = txq.pop_front();
               chk(tx_acc == e, "R4 transmitted byte", tx_acc, e);
            end
            oe_cnt = 0; tx_bits = 0; xfer_rises = 0;
         end
         if (rx_done && !prev_rxd) begin
            chk(rx_rises == 8, "R5 rx rising edges", rx_rises, 8);
            if (rxq.size() == 0) begin
               chk(1'b0, "R9 unexpected reception", rx_byte, 0);
            end else begin
               logic [7:0] e;
               e = rxq.pop_front();
               chk(rx_byte == e, "R6 received byte", rx_byte, e);
            end
            rx_rises = 0; xfer_rises = 0; slave_idx = 0;
         end
         prev_sclk = sclk; prev_oe = sd_oe; prev_sd = sd_out; prev_rxd = rx_done;
      end
   end

   task automatic wait_tx_done();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (tx_done) break;
      end
      chk(tx_done == 1'b1, "R7 tx_done set", tx_done, 1);
   endtask

   task automatic wait_rx_done();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (rx_done) break;
      end
      chk(rx_done == 1'b1, "R7 rx_done set", rx_done, 1);
   endtask

   task automatic clear_tx();
      @(negedge clk); tx_done_clr = 1'b1;
      @(negedge clk); tx_done_clr = 1'b0;
      chk(tx_done == 1'b0, "R7 tx_done cleared", tx_done, 0);
   endtask

   task automatic clear_rx();
      @(negedge clk); rx_done_clr = 1'b1;
      @(negedge clk); rx_done_clr = 1'b0;
      chk(rx_done == 1'b0, "R7 rx_done cleared", rx_done, 0);
   endtask

   task automatic send_byte(input logic [7:0] b);
      txq.push_back(b);
      @(negedge clk); tx_wr = 1'b1; tx_byte = b;
      @(negedge clk); tx_wr = 1'b0;
      chk(sd_oe == 1'b1, "R2 oe after write", sd_oe, 1);
      wait_tx_done();
      repeat (5) @(negedge clk);
      chk(tx_done == 1'b1, "R7 tx_done sticky", tx_done, 1);
      clear_tx();
   endtask

   task automatic recv_byte(input logic [7:0] b);
      slave_byte = b; slave_idx = 0;
      rxq.push_back(b);
      @(negedge clk); rx_en = 1'b1;
      @(negedge clk); rx_en = 1'b0;
      chk(sd_oe == 1'b0, "R5 no drive in receive", sd_oe, 0);
      wait_rx_done();
      repeat (5) @(negedge clk);
      chk(rx_done == 1'b1, "R7 rx_done sticky", rx_done, 1);
      clear_rx();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sclk == 1'b1, "R1 sclk idle", sclk, 1);
      chk(sd_oe == 1'b0, "R1 oe idle", sd_oe, 0);
      chk(tx_done == 1'b0, "R1 tx_done", tx_done, 0);
      chk(rx_done == 1'b0, "R1 rx_done", rx_done, 0);
      chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);

      // R2 R4 transmit patterns
      send_byte(8'hA5);
      send_byte(8'h01);
      send_byte(8'h80);
      send_byte(8'hFF);
      send_byte(8'h00);

      // R5 R6 receive patterns
      recv_byte(8'h3C);
      recv_byte(8'hC3);
      recv_byte(8'h81);

      // R8 write strobe during a transfer
      txq.push_back(8'h5A);
      @(negedge clk); tx_wr = 1'b1; tx_byte = 8'h5A;
      @(negedge clk); tx_wr = 1'b0;
      repeat (30) @(negedge clk);
      tx_wr = 1'b1; tx_byte = 8'hFF;
      @(negedge clk); tx_wr = 1'b0;
      wait_tx_done();
      repeat (20) @(negedge clk);
      chk(sd_oe == 1'b0, "R8 no second transmission", sd_oe, 0);
      chk(txq.size() == 0, "R8 queue drained", txq.size(), 0);
      clear_tx();

      // R9 rx_en held with rx_done set, then re-arm by clearing
      slave_byte = 8'h96; slave_idx = 0; rxq.push_back(8'h96);
      @(negedge clk); rx_en = 1'b1;
      wait_rx_done();
      begin
         int falls_before;
         falls_before = total_falls;
         repeat (50) @(negedge clk);
         chk(total_falls == falls_before, "R9 no shift clock while done", total_falls, falls_before);
         chk(sclk == 1'b1, "R9 sclk idle", sclk, 1);
      end
      slave_byte = 8'h4B; slave_idx = 0; rxq.push_back(8'h4B);
      clear_rx();
      @(negedge clk); rx_en = 1'b0;
      wait_rx_done();
      clear_rx();

      // R10 simultaneous transmit and receive start
      txq.push_back(8'hE7);
      @(negedge clk); tx_wr = 1'b1; tx_byte = 8'hE7; rx_en = 1'b1;
      @(negedge clk); tx_wr = 1'b0; rx_en = 1'b0;
      chk(sd_oe == 1'b1, "R10 transmit wins", sd_oe, 1);
      wait_tx_done();
      clear_tx();
      repeat (20) @(negedge clk);
      chk(rxq.size() == 0 && txq.size() == 0, "R10 no leftover items", rxq.size() + txq.size(), 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule